// File: doc/BRIEF.md
# Byte-Packing Hash Input Buffer

This block sits in front of a block-hash engine. Software or a DMA engine writes input data to one data port in 8-, 16- or 32-bit pieces. The block gathers those pieces into complete 32-bit words, least significant byte first. Only finished words go to the hash core, over a valid/ready handshake. The buffer holds 256 bytes. Its fill level is counted in bytes, so a partly assembled word still counts toward occupancy.

A write whose bytes do not all fit is dropped as a whole and raises a sticky overflow flag. An underrun flag exists for completeness. It cannot be set, because words are never taken from an empty store. Two DMA request outputs, one for single transfers and one for bursts, follow the free space in the buffer. An enable input gates both requests, and a burst-only input suppresses the single request. A synchronous soft clear drops all buffered data and clears both flags.

Top module: `bytepack_fifo`

## Requirements
- R1: Right after reset, the byte count is 0, both flags are low, `out_valid` is low and both DMA requests are low.
- R2: Write size codes are: 0 = one byte from bits 7:0, 1 = two bytes from bits 15:0, 2 = four bytes from bits 31:0. Bits above the selected width are ignored. Bytes are packed little-endian: the oldest byte lands in bits 7:0 of the word. A word is offered on `out_data` only once all four of its bytes are present.
- R3: A write that would raise the byte count above 256 is dropped in full and sets `ovf_flag`. The flag stays high until a soft clear.
- R4: `fill_bytes` equals the bytes accepted minus four for each word taken. It ranges from 0 to 256 and is updated on the clock edge that accepts the write or takes the word.
- R5: A word is taken on a cycle where `out_valid` and `out_ready` are both high. Words leave in the order they were completed. While `out_ready` is low, `out_valid` and `out_data` hold.
- R6: While `dma_enable` is low, both DMA requests are low from the next cycle on.
- R7: With DMA enabled, `dma_burst_req` is high when at least 16 bytes are free. `dma_single_req` is high when at least 4 bytes are free. Both follow the byte count of the same cycle.
- R8: While `dma_burst_only` is high, `dma_single_req` stays low, and `dma_burst_req` behaves as in R7.
- R9: A soft clear empties the buffer, including any partial word, and sets the byte count to 0. It clears `ovf_flag` and `udf_flag` on the next edge. It takes precedence over a write in the same cycle.
- R10: `udf_flag` never rises in operation, because no word is taken while the store is empty.
- R11: Size code 3 is reserved. A write with it has no effect on the byte count, the flags or the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Flush buffer and clear flags |
| dma_enable | input | 1 | Enables DMA request outputs |
| dma_burst_only | input | 1 | Restricts requests to bursts |
| wr_en | input | 1 | Write strobe for the data port |
| wr_size | input | 2 | Write width code (see R2, R11) |
| wr_data | input | 32 | Write data, right-aligned |
| out_valid | output | 1 | A complete word is available |
| out_ready | input | 1 | Hash core accepts the word |
| out_data | output | 32 | Oldest complete word |
| fill_bytes | output | 9 | Occupancy in bytes, 0 to 256 |
| ovf_flag | output | 1 | Sticky overflow |
| udf_flag | output | 1 | Sticky underrun |
| dma_single_req | output | 1 | Single-transfer request |
| dma_burst_req | output | 1 | Burst-transfer request |

## Verification
Every registered result (`fill_bytes`, the flags, `out_valid` and both DMA requests) changes on the first rising edge after the write, pop or control change that causes it, so each is due one cycle later. `out_data` comes combinationally from the head of the store, so it is correct as soon as `out_valid` is high. The bench drives all inputs on the falling edge and samples one falling edge after the rising edge that consumes them. It checks `out_data` before raising `out_ready`, so every sample falls half a period clear of the edge that makes it.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } wr_size_e;

  function automatic logic [2:0] size_bytes(input wr_size_e sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      SZ_WORD: size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/hbf_packer.sv
module hbf_packer
  import hbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_acc,
  input  logic [2:0]        nbytes,
  input  logic [WORD_W-1:0] wr_data,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);

  localparam int HOLD_W = WORD_W - 8;
  localparam int COMB_W = WORD_W + HOLD_W;

  logic [HOLD_W-1:0] hold_q;
  logic [1:0]        pend_q;
  logic [WORD_W-1:0] masked;
  logic [COMB_W-1:0] merged;
  logic [2:0]        total;

  always_comb begin
    case (nbytes)
      3'd1:    masked = {24'b0, wr_data[7:0]};
      3'd2:    masked = {16'b0, wr_data[15:0]};
      default: masked = wr_data;
    endcase
    merged = {{WORD_W{1'b0}}, hold_q} |
             ({{HOLD_W{1'b0}}, masked} << {pend_q, 3'b000});
    total     = {1'b0, pend_q} + nbytes;
    push      = wr_acc && (total >= 3'd4);
    push_word = merged[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hold_q <= '0;
      pend_q <= '0;
    end else if (wr_acc) begin
      if (total >= 3'd4) begin
        hold_q <= merged[COMB_W-1:WORD_W];
        pend_q <= 2'(total - 3'd4);
      end else begin
        hold_q <= merged[HOLD_W-1:0];
        pend_q <= total[1:0];
      end
    end
  end

endmodule

// File: rtl/hbf_word_store.sv
module hbf_word_store #(
  parameter int DEPTH = 64,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         valid,
  output logic         underrun_evt
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  assign do_pop       = pop && (cnt_q != '0);
  assign underrun_evt = pop && (cnt_q == '0);
  assign rdata        = mem[rptr_q];
  assign valid        = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push)   wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/hbf_dma_req.sv
module hbf_dma_req #(
  parameter int FREE_W      = 9,
  parameter int BURST_FREE  = 16,
  parameter int SINGLE_FREE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              burst_only,
  input  logic [FREE_W-1:0] free_nx,
  output logic              single_req,
  output logic              burst_req
);

  localparam logic [FREE_W-1:0] BURST_LIM  = FREE_W'(BURST_FREE);
  localparam logic [FREE_W-1:0] SINGLE_LIM = FREE_W'(SINGLE_FREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      single_req <= 1'b0;
      burst_req  <= 1'b0;
    end else begin
      single_req <= enable && !burst_only && (free_nx >= SINGLE_LIM);
      burst_req  <= enable && (free_nx >= BURST_LIM);
    end
  end

endmodule

// File: rtl/bytepack_fifo.sv
module bytepack_fifo
  import hbf_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  parameter int BURST_FREE  = 16,
  parameter int SINGLE_FREE = 4,
  localparam int CAP_BYTES  = DEPTH_WORDS * WORD_BYTES,
  localparam int FILL_W     = $clog2(CAP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_clr,
  input  logic              dma_enable,
  input  logic              dma_burst_only,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [31:0]       wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic [FILL_W-1:0] fill_bytes,
  output logic              ovf_flag,
  output logic              udf_flag,
  output logic              dma_single_req,
  output logic              dma_burst_req
);

  localparam int SUM_W = FILL_W + 1;
  localparam logic [SUM_W-1:0] CAP_S = SUM_W'(CAP_BYTES);

  logic [2:0]        nb;
  logic [SUM_W-1:0]  room_need;
  logic              fits, wr_acc, ovf_evt, pop, udf_evt;
  logic              push;
  logic [31:0]       push_word;
  logic [FILL_W-1:0] fill_nx, free_nx;

  always_comb begin
    nb        = size_bytes(wr_size_e'(wr_size));
    room_need = {1'b0, fill_bytes} + SUM_W'(nb);
    fits      = (room_need <= CAP_S);
    wr_acc    = wr_en && !soft_clr && (nb != 3'd0) && fits;
    ovf_evt   = wr_en && !soft_clr && (nb != 3'd0) && !fits;
    pop       = out_valid && out_ready && !soft_clr;
    if (soft_clr) begin
      fill_nx = '0;
    end else begin
      fill_nx = fill_bytes + (wr_acc ? FILL_W'(nb) : '0)
                           - (pop ? FILL_W'(WORD_BYTES) : '0);
    end
    free_nx = FILL_W'(CAP_BYTES) - fill_nx;
  end

  hbf_packer i_packer (
    .clk       (clk),
    .rst       (rst),
    .clr       (soft_clr),
    .wr_acc    (wr_acc),
    .nbytes    (nb),
    .wr_data   (wr_data),
    .push      (push),
    .push_word (push_word)
  );

  hbf_word_store #(.DEPTH(DEPTH_WORDS), .W(WORD_W)) i_store (
    .clk          (clk),
    .rst          (rst),
    .clr          (soft_clr),
    .push         (push),
    .wdata        (push_word),
    .pop          (pop),
    .rdata        (out_data),
    .valid        (out_valid),
    .underrun_evt (udf_evt)
  );

  hbf_dma_req #(
    .FREE_W     (FILL_W),
    .BURST_FREE (BURST_FREE),
    .SINGLE_FREE(SINGLE_FREE)
  ) i_dma (
    .clk        (clk),
    .rst        (rst),
    .enable     (dma_enable),
    .burst_only (dma_burst_only),
    .free_nx    (free_nx),
    .single_req (dma_single_req),
    .burst_req  (dma_burst_req)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      fill_bytes <= '0;
      ovf_flag   <= 1'b0;
      udf_flag   <= 1'b0;
    end else begin
      fill_bytes <= fill_nx;
      if (ovf_evt) ovf_flag <= 1'b1;
      if (udf_evt) udf_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/bytepack_fifo_checker.sv
module bytepack_fifo_checker #(
  parameter int FILL_W    = 9,
  parameter int CAP_BYTES = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_clr,
  input logic              dma_enable,
  input logic              dma_burst_only,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_data,
  input logic [FILL_W-1:0] fill_bytes,
  input logic              ovf_flag,
  input logic              udf_flag,
  input logic              dma_single_req,
  input logic              dma_burst_req
);

  p_fill_range_r4: assert property (@(posedge clk) disable iff (rst)
    fill_bytes <= FILL_W'(CAP_BYTES));

  p_valid_has_word_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> fill_bytes >= FILL_W'(4));

  p_hold_when_stalled_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !soft_clr) |=> (out_valid && $stable(out_data)));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !soft_clr) |=> ovf_flag);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (fill_bytes == '0 && !ovf_flag && !udf_flag && !out_valid));

  p_no_underrun_r10: assert property (@(posedge clk) disable iff (rst)
    !udf_flag);

  p_dma_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !dma_enable |=> (!dma_single_req && !dma_burst_req));

  p_burst_only_r8: assert property (@(posedge clk) disable iff (rst)
    dma_burst_only |=> !dma_single_req);

endmodule

bind bytepack_fifo bytepack_fifo_checker #(
  .FILL_W   (FILL_W),
  .CAP_BYTES(CAP_BYTES)
) i_checker (
  .clk           (clk),
  .rst           (rst),
  .soft_clr      (soft_clr),
  .dma_enable    (dma_enable),
  .dma_burst_only(dma_burst_only),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .fill_bytes    (fill_bytes),
  .ovf_flag      (ovf_flag),
  .udf_flag      (udf_flag),
  .dma_single_req(dma_single_req),
  .dma_burst_req (dma_burst_req)
);

// File: tb/test_bytepack_fifo.sv
module test_bytepack_fifo;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_clr = 1'b0;
  logic        dma_enable = 1'b0;
  logic        dma_burst_only = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = 2'd0;
  logic [31:0] wr_data = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [8:0]  fill_bytes;
  logic        ovf_flag, udf_flag, dma_single_req, dma_burst_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bytepack_fifo i_bytepack_fifo (
    .clk(clk), .rst(rst), .soft_clr(soft_clr),
    .dma_enable(dma_enable), .dma_burst_only(dma_burst_only),
    .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fill_bytes(fill_bytes), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
    .dma_single_req(dma_single_req), .dma_burst_req(dma_burst_req)
  );

  // {size[1:0], data[31:0], expected fill[8:0], expected out_valid}
  localparam logic [43:0] VEC [0:7] = '{
    {2'd0, 32'hABCDEF11, 9'd1,  1'b0},
    {2'd0, 32'h00000022, 9'd2,  1'b0},
    {2'd1, 32'h77774433, 9'd4,  1'b1},
    {2'd2, 32'h88776655, 9'd8,  1'b1},
    {2'd0, 32'h00000099, 9'd9,  1'b1},
    {2'd2, 32'hDDCCBBAA, 9'd13, 1'b1},
    {2'd1, 32'h5555FFEE, 9'd15, 1'b1},
    {2'd0, 32'h00000012, 9'd16, 1'b1}
  };
  localparam logic [31:0] WORDS [0:3] = '{
    32'h44332211, 32'h88776655, 32'hCCBBAA99, 32'h12FFEEDD
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] d);
    wr_en = 1'b1; wr_size = sz; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 fill", 32'(fill_bytes), 0);
    chk("R1 flags", {30'b0, ovf_flag, udf_flag}, 0);
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 reqs", {30'b0, dma_single_req, dma_burst_req}, 0);

    // table walk: R2 packing, R4 byte count
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][43:42], VEC[i][41:10]);
      chk("R4 fill", 32'(fill_bytes), 32'(VEC[i][9:1]));
      chk("R2 word complete", 32'(out_valid), 32'(VEC[i][0]));
    end

    // R11 reserved size has no effect
    wr(2'd3, 32'hFFFFFFFF);
    chk("R11 fill", 32'(fill_bytes), 16);
    chk("R11 ovf", 32'(ovf_flag), 0);
    chk("R11 head", out_data, WORDS[0]);

    // R5 stall holds head, then drain in order
    step();
    chk("R5 hold", out_data, WORDS[0]);
    for (int i = 0; i < 4; i++) begin
      chk("R2 R5 data", out_data, WORDS[i]);
      out_ready = 1'b1;
      step();
      out_ready = 1'b0;
      chk("R5 fill", 32'(fill_bytes), 32'(12 - 4 * i));
    end
    chk("R5 empty", 32'(out_valid), 0);

    // R7 thresholds with DMA enabled
    dma_enable = 1'b1;
    step();
    chk("R7 empty reqs", {30'b0, dma_single_req, dma_burst_req}, 32'h3);
    for (int i = 0; i < 61; i++) wr(2'd2, 32'(i));
    chk("R7 free12", {30'b0, dma_single_req, dma_burst_req}, 32'h2);
    wr(2'd2, 0); wr(2'd2, 0);
    chk("R7 free4", {30'b0, dma_single_req, dma_burst_req}, 32'h2);
    wr(2'd0, 0);
    chk("R7 free3 fill", 32'(fill_bytes), 253);
    chk("R7 free3", {30'b0, dma_single_req, dma_burst_req}, 0);

    // R3 overflow: dropped whole, sticky
    wr(2'd2, 32'h1234);
    chk("R3 dropped", 32'(fill_bytes), 253);
    chk("R3 ovf", 32'(ovf_flag), 1);
    wr(2'd0, 0); wr(2'd1, 0);
    chk("R4 full", 32'(fill_bytes), 256);
    chk("R3 sticky", 32'(ovf_flag), 1);
    wr(2'd0, 0);
    chk("R3 full drop", 32'(fill_bytes), 256);

    // R9 soft clear beats a simultaneous write
    soft_clr = 1'b1;
    wr(2'd2, 32'h5A5A5A5A);
    soft_clr = 1'b0;
    chk("R9 fill", 32'(fill_bytes), 0);
    chk("R9 ovf", 32'(ovf_flag), 0);
    chk("R9 valid", 32'(out_valid), 0);
    chk("R7 after clear", {30'b0, dma_single_req, dma_burst_req}, 32'h3);

    // R9 partial word flushed: new bytes start a fresh word
    wr(2'd0, 32'h01);
    soft_clr = 1'b1; step(); soft_clr = 1'b0;
    wr(2'd2, 32'hCAFEF00D);
    chk("R9 partial flushed", out_data, 32'hCAFEF00D);
    chk("R9 fill4", 32'(fill_bytes), 4);

    // R8 burst only
    dma_burst_only = 1'b1;
    step();
    chk("R8 reqs", {30'b0, dma_single_req, dma_burst_req}, 32'h1);

    // R6 gate
    dma_enable = 1'b0;
    step();
    chk("R6 reqs", {30'b0, dma_single_req, dma_burst_req}, 0);

    chk("R10 udf", 32'(udf_flag), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule